// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block performs the entry steps of a processor exception once the surrounding core has picked a vector number and a return address. On a start pulse it keeps a copy of the current 16-bit status word and derives a live status word from it, with supervisor mode forced on and tracing forced off. It then pushes the return program counter and the unmodified status copy onto the supervisor stack through a word-wide memory port. Last, it reads the 32-bit handler address from the vector table and reports it together with a one-cycle done pulse.

The same steps serve every exception kind, such as a privilege violation or a trace trap. The caller supplies the correct return address: for a privilege violation that is the address of the first word of the offending instruction. Stacking always uses the supervisor stack pointer supplied on `ssp_in`, whatever mode the status word shows. Every memory transfer uses a request/acknowledge handshake, so the port tolerates any number of wait states.

Top module: `exc_entry_seq`

## Requirements
- R1: During and right after synchronous reset, `busy`, `done` and `mem_req` are low. A reset in the middle of a sequence abandons it.
- R2: From the cycle after an accepted start until done, `sr_out` equals the captured status word with bit 13 (supervisor) set and bit 15 (trace) cleared, and all other bits unchanged.
- R3: Exactly three memory writes (`mem_we`=1) are made, in this order: address `ssp_in`-2 with PC[15:0], address `ssp_in`-4 with PC[31:16], then address `ssp_in`-6 with the status word.
- R4: The stacked status word is the value of `sr_in` at start, taken before any mode bit changes.
- R5: When done, `ssp_out` equals `ssp_in` minus 6, using modulo 2^32 arithmetic.
- R6: Two reads (`mem_we`=0) follow the writes: the high word at VEC_BASE + 4×vector, then the low word at that address + 2. When `done` is high, `new_pc` equals {high, low}.
- R7: `done` is high for exactly one cycle per sequence. `busy` is high from the cycle after the accepted start up to and including the done cycle.
- R8: A start pulse while `busy` is high is ignored. Input values presented with it do not change the addresses, data or result of the running sequence.
- R9: A transfer holds `mem_req`, `mem_addr` and `mem_wdata` steady until `mem_ack`. Each acknowledge completes exactly one transfer.
- R10: Stack addresses come from `ssp_in` whether bit 13 of `sr_in` is clear (user) or set (supervisor).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| vec_num | input | VEC_W | Vector number selecting the table entry |
| ret_pc | input | 32 | Return program counter to stack |
| sr_in | input | 16 | Current status word |
| ssp_in | input | 32 | Supervisor stack pointer before entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address read from the table |
| sr_out | output | 16 | Live status word after entry |
| ssp_out | output | 32 | Supervisor stack pointer after entry |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Transfer acknowledge |
| mem_rdata | input | 16 | Read data, valid with acknowledge |

## Verification
The bench builds the block with VEC_W = 8 and VEC_BASE = 0x400. The nonzero base shows that the table offset is added to the scaled vector rather than replacing it. Vector 255 reaches the highest table words at 0x7FC and 0x7FE. The bench memory model answers with 0 to 3 wait states per case, which exercises the handshake hold rules. Stack pointers near zero and near the top of the address space exercise address wrap.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int WORD_W       = 16;
    localparam int PC_W         = 32;
    localparam int SR_TRACE_BIT = 15;
    localparam int SR_SUPER_BIT = 13;
    localparam int STEP_BYTES   = WORD_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_SR,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [PC_W-1:0]   ret_pc;
        logic [WORD_W-1:0] sr_copy;
    } entry_ctx_t;

    function automatic logic [WORD_W-1:0] enter_super(input logic [WORD_W-1:0] sr);
        logic [WORD_W-1:0] r;
        r = sr;
        r[SR_TRACE_BIT] = 1'b0;
        r[SR_SUPER_BIT] = 1'b1;
        return r;
    endfunction

    function automatic logic is_push(input seq_state_e s);
        return (s == ST_PUSH_PCL) || (s == ST_PUSH_PCH) || (s == ST_PUSH_SR);
    endfunction

    function automatic logic is_xfer(input seq_state_e s);
        return is_push(s) || (s == ST_VEC_HI) || (s == ST_VEC_LO);
    endfunction

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mem_ack,
    output seq_state_e state,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       mem_req,
    output logic       mem_we
);

    seq_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start)   state_nx = ST_PUSH_PCL;
            ST_PUSH_PCL: if (mem_ack) state_nx = ST_PUSH_PCH;
            ST_PUSH_PCH: if (mem_ack) state_nx = ST_PUSH_SR;
            ST_PUSH_SR:  if (mem_ack) state_nx = ST_VEC_HI;
            ST_VEC_HI:   if (mem_ack) state_nx = ST_VEC_LO;
            ST_VEC_LO:   if (mem_ack) state_nx = ST_FINISH;
            ST_FINISH:                state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign accept  = (state == ST_IDLE) && start;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_FINISH);
    assign mem_req = is_xfer(state);
    assign mem_we  = is_push(state);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R8
    restart_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> busy);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !mem_req && !done));

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
    import exc_entry_pkg::*;
#(
    parameter int               VEC_W    = 8,
    parameter logic [PC_W-1:0]  VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              accept,
    input  logic              mem_req,
    input  logic              mem_ack,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [PC_W-1:0]   ret_pc,
    input  logic [WORD_W-1:0] sr_in,
    input  logic [PC_W-1:0]   ssp_in,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [PC_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] sr_out,
    output logic [PC_W-1:0]   ssp_out,
    output logic [PC_W-1:0]   new_pc
);

    localparam int PAD_W = PC_W - VEC_W - 2;

    entry_ctx_t        ctx;
    logic [WORD_W-1:0] sr_live;
    logic [PC_W-1:0]   sp;
    logic [VEC_W-1:0]  vec;
    logic [WORD_W-1:0] hi_word;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   vec_addr;
    logic [PC_W-1:0]   sp_dec;

    assign sp_dec   = sp - PC_W'(STEP_BYTES);
    assign vec_addr = VEC_BASE + {{PAD_W{1'b0}}, vec, 2'b00};

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_PCL: begin
                mem_addr  = sp_dec;
                mem_wdata = ctx.ret_pc[WORD_W-1:0];
            end
            ST_PUSH_PCH: begin
                mem_addr  = sp_dec;
                mem_wdata = ctx.ret_pc[PC_W-1:WORD_W];
            end
            ST_PUSH_SR: begin
                mem_addr  = sp_dec;
                mem_wdata = ctx.sr_copy;
            end
            ST_VEC_HI: mem_addr = vec_addr;
            ST_VEC_LO: mem_addr = vec_addr + PC_W'(STEP_BYTES);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx     <= '0;
            sr_live <= '0;
            sp      <= '0;
            vec     <= '0;
            hi_word <= '0;
            pc_q    <= '0;
        end else if (accept) begin
            ctx.ret_pc  <= ret_pc;
            ctx.sr_copy <= sr_in;
            sr_live     <= enter_super(sr_in);
            sp          <= ssp_in;
            vec         <= vec_num;
        end else if (mem_ack) begin
            if (is_push(state))     sp      <= sp_dec;
            if (state == ST_VEC_HI) hi_word <= mem_rdata;
            if (state == ST_VEC_LO) pc_q    <= {hi_word, mem_rdata};
        end
    end

    assign sr_out  = sr_live;
    assign ssp_out = sp;
    assign new_pc  = pc_q;

    // R9
    xfer_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));

    // R2
    sr_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (sr_out[SR_SUPER_BIT] && !sr_out[SR_TRACE_BIT]));

    // R4
    stacked_sr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSH_SR) |-> (sr_out == enter_super(mem_wdata)));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int              VEC_W    = 8,
    parameter logic [31:0]     VEC_BASE = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VEC_W-1:0] vec_num,
    input  logic [31:0]      ret_pc,
    input  logic [15:0]      sr_in,
    input  logic [31:0]      ssp_in,
    output logic             busy,
    output logic             done,
    output logic [31:0]      new_pc,
    output logic [15:0]      sr_out,
    output logic [31:0]      ssp_out,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [15:0]      mem_rdata
);

    seq_state_e state;
    logic       accept;

    exc_entry_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mem_ack (mem_ack),
        .state   (state),
        .accept  (accept),
        .busy    (busy),
        .done    (done),
        .mem_req (mem_req),
        .mem_we  (mem_we)
    );

    exc_entry_dp #(
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .accept    (accept),
        .mem_req   (mem_req),
        .mem_ack   (mem_ack),
        .vec_num   (vec_num),
        .ret_pc    (ret_pc),
        .sr_in     (sr_in),
        .ssp_in    (ssp_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sr_out    (sr_out),
        .ssp_out   (ssp_out),
        .new_pc    (new_pc)
    );

endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

    localparam int          CLK_PERIOD = 10;
    localparam int          VEC_W      = 8;
    localparam logic [31:0] VEC_BASE   = 32'h0000_0400;
    localparam int          N_CASES    = 5;

    typedef struct packed {
        logic [7:0]  vec;
        logic [31:0] pc;
        logic [15:0] sr;
        logic [31:0] ssp;
        logic [1:0]  lat;
    } case_t;

    localparam case_t CASES [N_CASES] = '{
        '{8'h08, 32'h0000_1234, 16'h0700, 32'h0000_8000, 2'd0},
        '{8'h09, 32'hDEAD_BEE0, 16'h8004, 32'h0001_0000, 2'd1},
        '{8'hFF, 32'h00FF_FF00, 16'hA71F, 32'h0000_0006, 2'd3},
        '{8'h00, 32'h1357_9BDE, 16'h2000, 32'hFFFF_FFFE, 2'd2},
        '{8'h20, 32'h8000_0002, 16'hFFFF, 32'h0000_0004, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  vec_num = '0;
    logic [31:0] ret_pc = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] ssp_in = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] new_pc, ssp_out, mem_addr;
    logic [15:0] sr_out, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_exc_entry_seq (
        .clk(clk), .rst(rst), .start(start), .vec_num(vec_num), .ret_pc(ret_pc),
        .sr_in(sr_in), .ssp_in(ssp_in), .busy(busy), .done(done), .new_pc(new_pc),
        .sr_out(sr_out), .ssp_out(ssp_out), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] rd_word(input logic [31:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    // memory model with wait states and transfer log
    logic [1:0]  mem_lat = '0;
    logic        log_clr = 1'b0;
    logic [1:0]  wait_cnt = '0;
    logic [31:0] wlog_addr [8];
    logic [15:0] wlog_data [8];
    logic [31:0] rlog_addr [8];
    int          wcount = 0;
    int          rcount = 0;

    always @(posedge clk) begin
        if (log_clr) begin
            wcount   <= 0;
            rcount   <= 0;
            mem_ack  <= 1'b0;
            wait_cnt <= '0;
        end else if (mem_req && !mem_ack) begin
            if (wait_cnt == mem_lat) begin
                mem_ack  <= 1'b1;
                wait_cnt <= '0;
                if (mem_we) begin
                    if (wcount < 8) begin
                        wlog_addr[wcount] <= mem_addr;
                        wlog_data[wcount] <= mem_wdata;
                    end
                    wcount <= wcount + 1;
                end else begin
                    mem_rdata <= rd_word(mem_addr);
                    if (rcount < 8) rlog_addr[rcount] <= mem_addr;
                    rcount <= rcount + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 2'd1;
                mem_ack  <= 1'b0;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic run_case(input case_t c, input bit restart);
        logic [31:0] va;
        logic [15:0] exp_sr;
        int          done_cnt;
        bit          busy_gap;
        bit          finished;
        va       = VEC_BASE + {22'd0, c.vec, 2'b00};
        exp_sr   = (c.sr & 16'h7FFF) | 16'h2000;
        done_cnt = 0;
        busy_gap = 1'b0;
        finished = 1'b0;
        mem_lat  = c.lat;
        clear_log();
        vec_num = c.vec; ret_pc = c.pc; sr_in = c.sr; ssp_in = c.ssp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", {31'd0, busy}, 32'd1);
        chk(sr_out == exp_sr, "R2 live status", {16'd0, sr_out}, {16'd0, exp_sr});
        for (int k = 0; k < 100; k++) begin
            if (restart && k == 2) begin
                start = 1'b1; vec_num = ~c.vec; ret_pc = ~c.pc; sr_in = ~c.sr; ssp_in = c.ssp + 32'h100;
            end
            if (restart && k == 3) start = 1'b0;
            if (done) begin
                done_cnt++;
                finished = 1'b1;
                chk(new_pc == {rd_word(va), rd_word(va + 32'd2)}, "R6 handler pc",
                    new_pc, {rd_word(va), rd_word(va + 32'd2)});
                chk(ssp_out == c.ssp - 32'd6, "R5 stack pointer", ssp_out, c.ssp - 32'd6);
                chk(sr_out == exp_sr, "R2 status at done", {16'd0, sr_out}, {16'd0, exp_sr});
            end else if (finished) begin
                break;
            end else if (!busy) begin
                busy_gap = 1'b1;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done_cnt == 1, "R7 single done pulse", done_cnt, 32'd1);
        chk(!busy_gap && !busy, "R7 busy window", {31'd0, busy}, 32'd0);
        chk(wcount == 3, "R3 write count", wcount, 32'd3);
        chk(wlog_addr[0] == c.ssp - 32'd2 && wlog_data[0] == c.pc[15:0],
            "R3 R10 PC low push", wlog_addr[0], c.ssp - 32'd2);
        chk(wlog_addr[1] == c.ssp - 32'd4 && wlog_data[1] == c.pc[31:16],
            "R3 PC high push", {wlog_addr[1][15:0], wlog_data[1]}, {c.ssp[15:0] - 16'd4, c.pc[31:16]});
        chk(wlog_addr[2] == c.ssp - 32'd6 && wlog_data[2] == c.sr,
            "R4 stacked status", {16'd0, wlog_data[2]}, {16'd0, c.sr});
        chk(rcount == 2 && rlog_addr[0] == va && rlog_addr[1] == va + 32'd2,
            "R6 vector reads", rlog_addr[0], va);
        if (restart) chk(1'b1 && new_pc == {rd_word(va), rd_word(va + 32'd2)},
            "R8 restart ignored", new_pc, {rd_word(va), rd_word(va + 32'd2)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_req, "R1 reset outputs", {29'd0, busy, done, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 idle after reset", {29'd0, busy, done, mem_req}, 32'd0);

        for (int i = 0; i < N_CASES; i++) run_case(CASES[i], (i % 2) == 1);

        // R1: reset in the middle of a sequence
        mem_lat = 2'd3;
        clear_log();
        vec_num = 8'h05; ret_pc = 32'h0000_4000; sr_in = 16'h0000; ssp_in = 32'h0000_2000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 mid-sequence reset", {29'd0, busy, done, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 stays idle", {30'd0, busy, mem_req}, 32'd0);

        // R10: user-mode status with fresh stack after reset
        run_case('{8'h0B, 32'h0000_0100, 16'h0010, 32'h0000_0400, 2'd1}, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule